// File: doc/BRIEF.md
# Two-Branch Parallel Turbo Encoder

This block turns a frame of N message bits into a stream of N coded triplets. Each triplet holds the message bit, a parity bit from a first recursive systematic encoder that walks the frame in natural order, and a parity bit from a second, identical encoder that walks the frame in the order set by a programmable permutation table. The two parity encoders each have eight states.

The second encoder needs bits in permuted order, so the block first captures the whole frame into an internal bit buffer. Encoding starts in the cycle after the last message bit arrives. A loader writes the permutation table through a simple write port before the frame is sent. Entry k holds the buffer address that the second encoder reads at step k. The frame length is given with the start-of-frame bit and may be any value from 1 to the maximum length parameter.

Top module: `tenc_top`

## Requirements
- R1: After reset, out_valid and out_eof are low and stay low until a frame has been fully received.
- R2: A frame of length N (in_len carries N directly, 1..MAX_LEN, sampled with the start bit) yields exactly N triplets on N consecutive clocks. out_sys of triplet k equals message bit k, where bit 0 is the one sent with in_sof.
- R3: out_p1 of triplet k is the parity of a recursive encoder fed message bits 0..k in natural order. With state (s1,s2,s3) and input x, the encoder forms f = x^s2^s3, emits parity f^s1^s3, and moves to (f,s1,s2).
- R4: out_p2 of triplet k is the parity of the same kind of encoder fed, at each step j = 0..k, the message bit stored at the buffer address held in permutation entry j.
- R5: The first triplet is valid on the second rising clock edge after the edge that captures the last message bit.
- R6: out_eof is high with the final triplet of a frame only, and out_valid is low on the clock after it.
- R7: Both parity encoders restart from state 000 at the start of every frame, so a frame's triplets do not depend on earlier frames.
- R8: Clocks with in_valid low during loading are skipped, and the bits that follow keep their positions.
- R9: in_valid and in_sof are ignored while triplets are being produced. No extra frame is started by them.
- R10: A start-of-frame bit that arrives while a frame is still loading discards the partial frame and starts a new one.
- R11: The frame lengths 1 and MAX_LEN encode correctly.
- R12: perm_we high writes perm_data into permutation entry perm_addr. This entry is used by R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message bit present |
| in_sof | input | 1 | Marks the first bit of a frame |
| in_bit | input | 1 | Message bit |
| in_len | input | LW | Frame length N, sampled with in_sof |
| perm_we | input | 1 | Permutation table write enable |
| perm_addr | input | AW | Permutation entry index |
| perm_data | input | AW | Buffer address stored in the entry |
| out_valid | output | 1 | Triplet present |
| out_sys | output | 1 | Systematic (message) bit |
| out_p1 | output | 1 | Parity of the natural-order encoder |
| out_p2 | output | 1 | Parity of the permuted-order encoder |
| out_eof | output | 1 | Marks the last triplet of a frame |

## Verification
The hardest cases to reach are the ones where control input arrives at the wrong time. One is a start-of-frame bit in the middle of loading. The other is start and valid bits pushed in while triplets are still streaming. The stimulus reaches the first by sending a few bits of a longer frame and then a fresh start bit with a new length. It reaches the second by driving the start and valid inputs for several clocks just after the last bit. The bench then confirms that the output matches only the intended frame and that nothing follows its end marker. Reversed and rotated permutations keep the second parity stream different from the first, so an address path that skipped the table would show up.

// File: rtl/tenc_pkg.sv
package tenc_pkg;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_LOAD = 2'd1,
        TS_ENC  = 2'd2
    } tenc_state_e;

    // Constituent encoder state: bit 2 = s1 (newest), bit 0 = s3 (oldest)
    typedef logic [2:0] rsc_state_t;

endpackage

// File: rtl/tenc_rsc.sv
module tenc_rsc
    import tenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic din,
    output logic par
);

    rsc_state_t st_d, st_q;
    logic       fb;

    always_comb begin
        fb   = din ^ st_q[1] ^ st_q[0];
        par  = fb ^ st_q[2] ^ st_q[0];
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (adv) begin
            st_d = {fb, st_q[2], st_q[1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tenc_bitbuf.sv
module tenc_bitbuf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic          rbit_a,
    output logic          rbit_b
);

    logic [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wbit;
        rbit_a = mem_q[raddr_a];
        rbit_b = mem_q[raddr_b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

endmodule

// File: rtl/tenc_permtab.sv
module tenc_permtab #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [AW-1:0] rdata
);

    logic [AW-1:0] tab_d [DEPTH];
    logic [AW-1:0] tab_q [DEPTH];

    always_comb begin
        tab_d = tab_q;
        if (we) tab_d[waddr] = wdata;
        rdata = tab_q[raddr];
    end

    always_ff @(posedge clk) begin
        tab_q <= tab_d;
    end

endmodule

// File: rtl/tenc_top.sv
module tenc_top
    import tenc_pkg::*;
#(
    parameter int MAX_LEN = 64,
    localparam int AW = $clog2(MAX_LEN),
    localparam int LW = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_bit,
    input  logic [LW-1:0] in_len,
    input  logic          perm_we,
    input  logic [AW-1:0] perm_addr,
    input  logic [AW-1:0] perm_data,
    output logic          out_valid,
    output logic          out_sys,
    output logic          out_p1,
    output logic          out_p2,
    output logic          out_eof
);

    localparam int NENC = 2;

    typedef struct packed {
        tenc_state_e   st;
        logic [AW-1:0] idx;
        logic [LW-1:0] len;
        logic          ov;
        logic          sys;
        logic          p1;
        logic          p2;
        logic          eof;
    } ctl_t;

    ctl_t r_d, r_q;

    logic            buf_we;
    logic [AW-1:0]   buf_waddr;
    logic            bit_a, bit_b;
    logic [AW-1:0]   perm_rd;
    logic            enc_clr, enc_adv;
    logic [NENC-1:0] enc_in, enc_par;
    logic [LW-1:0]   len_in_c;
    logic [LW-1:0]   len_cur;
    logic            at_last;
    logic            sof_ok;

    tenc_bitbuf #(.DEPTH(MAX_LEN)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wbit    (in_bit),
        .raddr_a (r_q.idx),
        .raddr_b (perm_rd),
        .rbit_a  (bit_a),
        .rbit_b  (bit_b)
    );

    tenc_permtab #(.DEPTH(MAX_LEN)) u_perm (
        .clk   (clk),
        .we    (perm_we),
        .waddr (perm_addr),
        .wdata (perm_data),
        .raddr (r_q.idx),
        .rdata (perm_rd)
    );

    assign enc_in = {bit_b, bit_a};

    for (genvar g = 0; g < NENC; g++) begin : g_rsc
        tenc_rsc u_rsc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (enc_clr),
            .adv   (enc_adv),
            .din   (enc_in[g]),
            .par   (enc_par[g])
        );
    end

    always_comb begin
        r_d       = r_q;
        r_d.ov    = 1'b0;
        r_d.eof   = 1'b0;
        buf_we    = 1'b0;
        buf_waddr = r_q.idx;
        enc_clr   = 1'b0;
        enc_adv   = 1'b0;
        at_last   = (LW'(r_q.idx) == r_q.len - LW'(1));
        sof_ok    = in_valid && in_sof && (r_q.st != TS_ENC);

        if (in_len == '0)               len_in_c = LW'(1);
        else if (in_len > LW'(MAX_LEN)) len_in_c = LW'(MAX_LEN);
        else                            len_in_c = in_len;

        if (sof_ok) begin
            buf_we    = 1'b1;
            buf_waddr = '0;
            enc_clr   = 1'b1;
            r_d.len   = len_in_c;
            if (len_in_c == LW'(1)) begin
                r_d.st  = TS_ENC;
                r_d.idx = '0;
            end else begin
                r_d.st  = TS_LOAD;
                r_d.idx = AW'(1);
            end
        end else if (r_q.st == TS_LOAD && in_valid) begin
            buf_we = 1'b1;
            if (at_last) begin
                r_d.st  = TS_ENC;
                r_d.idx = '0;
            end else begin
                r_d.idx = r_q.idx + AW'(1);
            end
        end else if (r_q.st == TS_ENC) begin
            enc_adv = 1'b1;
            r_d.ov  = 1'b1;
            r_d.sys = bit_a;
            r_d.p1  = enc_par[0];
            r_d.p2  = enc_par[1];
            r_d.eof = at_last;
            if (at_last) begin
                r_d.st  = TS_IDLE;
                r_d.idx = '0;
            end else begin
                r_d.idx = r_q.idx + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign len_cur   = r_q.len;
    assign out_valid = r_q.ov;
    assign out_sys   = r_q.sys;
    assign out_p1    = r_q.p1;
    assign out_p2    = r_q.p2;
    assign out_eof   = r_q.eof;

endmodule

// File: rtl/tenc_chk.sv
module tenc_chk #(
    parameter int LW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_eof,
    input logic          out_sys,
    input logic          out_p1,
    input logic [LW-1:0] len_cur
);

    logic [LW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (out_eof)   run_q <= '0;
        else if (out_valid) run_q <= run_q + LW'(1);
    end

    // R6
    eof_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R6
    eof_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !out_valid);

    // R2
    stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eof) |=> out_valid);

    // R7
    fresh_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_p1 == out_sys));

    // R2
    frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> ((run_q + LW'(1)) == len_cur));

endmodule

bind tenc_top tenc_chk #(.LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_eof   (out_eof),
    .out_sys   (out_sys),
    .out_p1    (out_p1),
    .len_cur   (len_cur)
);

// File: tb/sim_tenc_top.sv
module sim_tenc_top;

    localparam int MAXN = 64;
    localparam int AW   = $clog2(MAXN);
    localparam int LW   = $clog2(MAXN + 1);

    typedef struct packed {
        logic [6:0]  len;
        logic [1:0]  mode;
        logic [63:0] msg;
        logic [7:0]  gaps;
    } frame_t;

    // mode: 0 identity, 1 reverse, 2 rotate by 3
    localparam frame_t TBL [0:5] = '{
        '{7'd8,  2'd0, 64'h00000000000000B5, 8'h00},
        '{7'd16, 2'd1, 64'h000000000000C3A1, 8'h00},
        '{7'd12, 2'd2, 64'h00000000000009F2, 8'h24},
        '{7'd1,  2'd0, 64'h0000000000000001, 8'h00},
        '{7'd64, 2'd1, 64'hDEADBEEF0123F00D, 8'h00},
        '{7'd20, 2'd2, 64'h000000000005A5A3, 8'h81}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_bit = 1'b0;
    logic [LW-1:0] in_len = '0;
    logic          perm_we = 1'b0;
    logic [AW-1:0] perm_addr = '0, perm_data = '0;
    logic          out_valid, out_sys, out_p1, out_p2, out_eof;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int mon_total = 0;
    int last_cyc = 0;
    logic m_sys [256];
    logic m_p1 [256];
    logic m_p2 [256];
    logic m_eof [256];
    int   m_cyc [256];
    int   tperm [MAXN];

    always #5 clk = ~clk;

    tenc_top #(.MAX_LEN(MAXN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_bit(in_bit), .in_len(in_len), .perm_we(perm_we),
        .perm_addr(perm_addr), .perm_data(perm_data), .out_valid(out_valid),
        .out_sys(out_sys), .out_p1(out_p1), .out_p2(out_p2), .out_eof(out_eof)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_valid) begin
            m_sys[mon_total % 256] = out_sys;
            m_p1[mon_total % 256]  = out_p1;
            m_p2[mon_total % 256]  = out_p2;
            m_eof[mon_total % 256] = out_eof;
            m_cyc[mon_total % 256] = cyc;
            mon_total = mon_total + 1;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_perm(input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            if (mode == 1)      tperm[k] = n - 1 - k;
            else if (mode == 2) tperm[k] = (k + 3) % n;
            else                tperm[k] = k;
            @(negedge clk);
            perm_we   = 1'b1;
            perm_addr = AW'(k);
            perm_data = AW'(tperm[k]);
        end
        @(negedge clk);
        perm_we = 1'b0;
    endtask

    // Independent parity model: f = x^s2^s3, parity = f^s1^s3, shift in f
    function automatic logic [63:0] parity_seq(input logic [63:0] msg,
                                               input int n, input bit permuted);
        logic s1 = 0, s2 = 0, s3 = 0, x, f;
        logic [63:0] r = '0;
        for (int k = 0; k < n; k++) begin
            x = permuted ? msg[tperm[k]] : msg[k];
            f = x ^ s2 ^ s3;
            r[k] = f ^ s1 ^ s3;
            s3 = s2; s2 = s1; s1 = f;
        end
        return r;
    endfunction

    task automatic send_frame(input int n, input logic [63:0] msg,
                              input logic [7:0] gaps);
        for (int k = 0; k < n; k++) begin
            if (k > 0 && gaps[k % 8]) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof   = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (k == 0);
            in_bit   = msg[k];
            in_len   = LW'(n);
            last_cyc = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic run_frame(input int n, input int mode, input logic [63:0] msg,
                             input logic [7:0] gaps, input bit inject,
                             input bit restart, input string tag);
        int base;
        logic [63:0] gs, g1, g2, ge, exp_sys, exp_eof;
        load_perm(n, mode);
        base = mon_total;
        if (restart) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sof   = (k == 0);
                in_bit   = 1'b1;
                in_len   = LW'(n + 7);
            end
        end
        send_frame(n, msg, gaps);
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                in_valid = 1'b1;
                in_sof   = 1'b1;
                in_bit   = 1'b1;
                in_len   = LW'(4);
                @(negedge clk);
            end
            in_valid = 1'b0;
            in_sof   = 1'b0;
        end
        for (int w = 0; w < n + 8 && mon_total < base + n; w++) @(negedge clk);
        repeat (6) @(negedge clk);
        gs = '0; g1 = '0; g2 = '0; ge = '0;
        for (int k = 0; k < n && base + k < mon_total; k++) begin
            gs[k] = m_sys[(base + k) % 256];
            g1[k] = m_p1[(base + k) % 256];
            g2[k] = m_p2[(base + k) % 256];
            ge[k] = m_eof[(base + k) % 256];
        end
        exp_sys = (n == 64) ? msg : (msg & ((64'd1 << n) - 64'd1));
        exp_eof = 64'd1 << (n - 1);
        chk(mon_total - base == n, {tag, " R2 triplet count"},
            64'(mon_total - base), 64'(n));
        chk(gs == exp_sys, {tag, " R2 systematic"}, gs, exp_sys);
        chk(g1 == parity_seq(msg, n, 1'b0), {tag, " R3 R7 parity1"},
            g1, parity_seq(msg, n, 1'b0));
        chk(g2 == parity_seq(msg, n, 1'b1), {tag, " R4 R12 parity2"},
            g2, parity_seq(msg, n, 1'b1));
        chk(ge == exp_eof, {tag, " R6 eof position"}, ge, exp_eof);
        chk(mon_total > base && m_cyc[base % 256] - last_cyc == 2,
            {tag, " R5 latency"},
            64'(m_cyc[base % 256] - last_cyc), 64'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired actual running expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_eof == 1'b0, "R1 in reset",
            64'({out_valid, out_eof}), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_eof == 1'b0 && mon_total == 0,
            "R1 after reset", 64'({out_valid, out_eof}), 64'd0);

        // table of frames: R2..R8, R11, R12
        for (int i = 0; i < 6; i++) begin
            run_frame(int'(TBL[i].len), int'(TBL[i].mode), TBL[i].msg,
                      TBL[i].gaps, 1'b0, 1'b0, $sformatf("tbl%0d", i));
        end

        // R9: start and valid driven during encoding are ignored
        run_frame(16, 2, 64'h0000_0000_0000_6C1B, 8'h00, 1'b1, 1'b0, "R9 inject");
        chk(out_valid == 1'b0, "R9 no output after frame", 64'(out_valid), 64'd0);

        // R10: start bit mid-load restarts the frame
        run_frame(5, 1, 64'h0000_0000_0000_0016, 8'h00, 1'b0, 1'b1, "R10 restart");

        // R8 + R11: maximum length with gaps, rotated permutation
        run_frame(64, 2, 64'h0F1E_2D3C_4B5A_6978, 8'h11, 1'b0, 1'b0, "R11 max gaps");

        // R7: same frame twice back to back gives identical results
        run_frame(9, 1, 64'h0000_0000_0000_01FF, 8'h00, 1'b0, 1'b0, "R7 first");
        run_frame(9, 1, 64'h0000_0000_0000_01FF, 8'h00, 1'b0, 1'b0, "R7 repeat");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule